// File: doc/BRIEF.md
# Two-Channel Interrupt Cause and Mask Unit

This block holds the interrupt state of a two-channel copy/parity engine. A single 32-bit cause word and a single 32-bit enable word are shared by both channels: each channel owns a 16-bit field, and channel `c` starts at bit `16*c` in both words. Event pulses from the engine set cause bits. Those bits stay set until software clears them.

Clearing uses inverted polarity. When software writes the cause word, every bit written as 0 is cleared. Every bit written as 1 is left as it was. A driver can therefore clear one channel's whole field without a read-modify-write by writing all ones over the other channel's field.

Each channel has one interrupt line. The line is raised when any cause bit of that channel is set and enabled. The unit also reports two error summaries per channel: address-decode errors on one output and all other errors on another.

Top module: `dual_irq_cause`

## Requirements
- R1: After synchronous reset, the cause and enable words read as 0 and all per-channel outputs are low.
- R2: An event pulse on `evt_i[n]` sets cause bit n at the next clock edge. The bit then stays set until software clears it.
- R3: A write to the cause word (address 0) clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a cause bit.
- R4: Writing 0x0000FFFF to the cause word clears only channel 1's field. Writing 0xFFFF0000 clears only channel 0's field. The other field is preserved in both cases.
- R5: When an event and a clearing write hit the same bit in the same cycle, the event wins and the bit ends set.
- R6: The enable word (address 1) reads back what was written. Writing it does not change the cause word.
- R7: `irq_o[c]` is high one cycle after any cause bit of field c is set while its enable bit is set.
- R8: Cause bits whose enable bit is 0 do not raise `irq_o`. One channel's bits never affect the other channel's line.
- R9: Within a field, bits 4 to 9 are error bits, and bit 5 is the address-decode error. `dec_err_o[c]` follows bit 5 of field c. `err_o[c]` is the OR of the other error bits of field c.
- R10: A read from an address other than 0 or 1 returns 0. A write to such an address changes nothing.
- R11: Read data appears on `rdata_o` one cycle after `rd_en_i` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 2 | Word address: 0 is cause, 1 is enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt_i | input | 32 | Event pulses, one per cause bit |
| irq_o | output | 2 | Per-channel interrupt line |
| dec_err_o | output | 2 | Per-channel address-decode error flag |
| err_o | output | 2 | Per-channel flag for other errors |

## Verification
Two functions can act on the same cause bit in one cycle: an event setting it and a clearing write. The bench provokes this by pulsing an event bit in the same cycle as a write of all zeros to the cause word. It then judges the result by reading the word back, which must show only that event bit still set. A second case clears one channel's field while the other channel's events are held, and confirms that the preserved field survives.

// File: rtl/icm_pkg.sv
package icm_pkg;

    // Field layout inside one channel's 16-bit slice
    localparam int unsigned EV_DESC_BIT  = 0;
    localparam int unsigned EV_CHAIN_BIT = 1;
    localparam int unsigned EV_STOP_BIT  = 2;
    localparam int unsigned ERR_LO_BIT   = 4;
    localparam int unsigned ERR_HI_BIT   = 9;
    localparam int unsigned DEC_ERR_BIT  = 5;

    // Register word addresses
    localparam logic [1:0] ADDR_CAUSE = 2'd0;
    localparam logic [1:0] ADDR_MASK  = 2'd1;

    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_CAUSE = 2'd1,
        RSEL_MASK  = 2'd2
    } rsel_e;

    typedef struct packed {
        logic  wr_cause;
        logic  wr_mask;
        logic  rd;
        rsel_e rsel;
    } bus_cmd_t;

    // Error bits excluding the decode error, as a 32-bit pattern
    function automatic logic [31:0] other_err_pattern();
        logic [31:0] m;
        m = '0;
        for (int i = ERR_LO_BIT; i <= ERR_HI_BIT; i++) begin
            if (i != DEC_ERR_BIT) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/icm_bus_decode.sv
module icm_bus_decode
    import icm_pkg::*;
(
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [1:0] addr_i,
    output bus_cmd_t   cmd_o
);
    always_comb begin
        cmd_o          = '0;
        cmd_o.rd       = rd_en_i;
        cmd_o.wr_cause = wr_en_i && (addr_i == ADDR_CAUSE);
        cmd_o.wr_mask  = wr_en_i && (addr_i == ADDR_MASK);
        unique case (addr_i)
            ADDR_CAUSE: cmd_o.rsel = RSEL_CAUSE;
            ADDR_MASK:  cmd_o.rsel = RSEL_MASK;
            default:    cmd_o.rsel = RSEL_NONE;
        endcase
    end
endmodule

// File: rtl/icm_field.sv
module icm_field
    import icm_pkg::*;
#(
    parameter int unsigned FIELD_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_cause_i,
    input  logic               wr_mask_i,
    input  logic [FIELD_W-1:0] wdata_i,
    input  logic [FIELD_W-1:0] evt_i,
    output logic [FIELD_W-1:0] cause_o,
    output logic [FIELD_W-1:0] mask_o,
    output logic               irq_o,
    output logic               dec_err_o,
    output logic               err_o
);
    localparam logic [31:0]        OTHER_ERR_W = other_err_pattern();
    localparam logic [FIELD_W-1:0] OTHER_ERR   = OTHER_ERR_W[FIELD_W-1:0];

    logic [FIELD_W-1:0] cause_q, cause_d;
    logic [FIELD_W-1:0] mask_q;
    logic               irq_q;

    // Clear-on-zero write, then merge events so an event outranks a clear
    always_comb begin
        cause_d = cause_q;
        if (wr_cause_i) cause_d = cause_q & wdata_i;
        cause_d = cause_d | evt_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            cause_q <= cause_d;
            if (wr_mask_i) mask_q <= wdata_i;
            irq_q   <= |(cause_q & mask_q);
        end
    end

    assign cause_o   = cause_q;
    assign mask_o    = mask_q;
    assign irq_o     = irq_q;
    assign dec_err_o = cause_q[DEC_ERR_BIT];
    assign err_o     = |(cause_q & OTHER_ERR);
endmodule

// File: rtl/icm_read_mux.sv
module icm_read_mux
    import icm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd_i,
    input  logic [DATA_W-1:0] cause_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] sel_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        unique case (cmd_i.rsel)
            RSEL_CAUSE: sel_d = cause_i;
            RSEL_MASK:  sel_d = mask_i;
            default:    sel_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           rdata_q <= '0;
        else if (cmd_i.rd) rdata_q <= sel_d;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/dual_irq_cause.sv
module dual_irq_cause
    import icm_pkg::*;
#(
    parameter int unsigned NUM_CH  = 2,
    parameter int unsigned FIELD_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en_i,
    input  logic                        rd_en_i,
    input  logic [1:0]                  addr_i,
    input  logic [NUM_CH*FIELD_W-1:0]   wdata_i,
    output logic [NUM_CH*FIELD_W-1:0]   rdata_o,
    input  logic [NUM_CH*FIELD_W-1:0]   evt_i,
    output logic [NUM_CH-1:0]           irq_o,
    output logic [NUM_CH-1:0]           dec_err_o,
    output logic [NUM_CH-1:0]           err_o
);
    localparam int unsigned DATA_W = NUM_CH * FIELD_W;

    bus_cmd_t          cmd;
    logic [DATA_W-1:0] cause_w;
    logic [DATA_W-1:0] mask_w;

    icm_bus_decode u_dec (
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .cmd_o   (cmd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        icm_field #(.FIELD_W(FIELD_W)) u_field (
            .clk        (clk),
            .rst        (rst),
            .wr_cause_i (cmd.wr_cause),
            .wr_mask_i  (cmd.wr_mask),
            .wdata_i    (wdata_i[c*FIELD_W +: FIELD_W]),
            .evt_i      (evt_i[c*FIELD_W +: FIELD_W]),
            .cause_o    (cause_w[c*FIELD_W +: FIELD_W]),
            .mask_o     (mask_w[c*FIELD_W +: FIELD_W]),
            .irq_o      (irq_o[c]),
            .dec_err_o  (dec_err_o[c]),
            .err_o      (err_o[c])
        );
    end

    icm_read_mux #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .cause_i (cause_w),
        .mask_i  (mask_w),
        .rdata_o (rdata_o)
    );
endmodule

// File: rtl/dual_irq_cause_chk.sv
module dual_irq_cause_chk
    import icm_pkg::*;
#(
    parameter int unsigned NUM_CH  = 2,
    parameter int unsigned FIELD_W = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en_i,
    input logic [1:0]                addr_i,
    input logic [NUM_CH*FIELD_W-1:0] evt_i,
    input logic [NUM_CH*FIELD_W-1:0] cause_w,
    input logic [NUM_CH*FIELD_W-1:0] mask_w,
    input logic [NUM_CH-1:0]         irq_o,
    input logic [NUM_CH-1:0]         err_o
);
    localparam logic [31:0] OTHER_ERR_W = other_err_pattern();
    localparam logic [31:0] DEC_ONLY    = 32'h1 << DEC_ERR_BIT;

    // R1: reset empties both words and the interrupt lines
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cause_w == '0) && (mask_w == '0) && (irq_o == '0));

    // R2: a set bit survives any cycle without a cause write
    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && addr_i == ADDR_CAUSE) |=> (($past(cause_w) & ~cause_w) == '0));

    // R5: an event always leaves its bit set
    p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((cause_w & $past(evt_i)) == $past(evt_i)));

    // R3: no bit rises without an event
    p_no_write_set_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cause_w & ~$past(cause_w) & ~$past(evt_i)) == '0));

    // R6: enable word holds when not written
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && addr_i == ADDR_MASK) |=> $stable(mask_w));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R8: nothing enabled-and-set means a quiet line next cycle
        p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
            ((cause_w[c*FIELD_W +: FIELD_W] & mask_w[c*FIELD_W +: FIELD_W]) == '0)
            |=> !irq_o[c]);
        // R7: an enabled set bit raises the line next cycle
        p_irq_raise_r7: assert property (@(posedge clk) disable iff (rst)
            ((cause_w[c*FIELD_W +: FIELD_W] & mask_w[c*FIELD_W +: FIELD_W]) != '0)
            |=> irq_o[c]);
        // R9: a lone decode error does not reach the general error flag
        p_dec_apart_r9: assert property (@(posedge clk) disable iff (rst)
            ((cause_w[c*FIELD_W +: FIELD_W] & (OTHER_ERR_W[FIELD_W-1:0] | DEC_ONLY[FIELD_W-1:0]))
              == DEC_ONLY[FIELD_W-1:0]) |-> !err_o[c]);
    end
endmodule

bind dual_irq_cause dual_irq_cause_chk #(.NUM_CH(NUM_CH), .FIELD_W(FIELD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .evt_i   (evt_i),
    .cause_w (cause_w),
    .mask_w  (mask_w),
    .irq_o   (irq_o),
    .err_o   (err_o)
);

// File: tb/dual_irq_cause_test.sv
module dual_irq_cause_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [31:0] evt_i = '0;
    logic [1:0]  irq_o, dec_err_o, err_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dual_irq_cause uut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i),
        .irq_o(irq_o), .dec_err_o(dec_err_o), .err_o(err_o)
    );

    // kind(2) | data(32) | expected cause(32) | expected irq(2)
    // kind: 0 event, 1 cause write, 2 enable write
    localparam int NV = 13;
    localparam logic [67:0] VECS [0:NV-1] = '{
        {2'd2, 32'h0001_0003, 32'h0000_0000, 2'b00},  // R6
        {2'd0, 32'h0000_0001, 32'h0000_0001, 2'b01},  // R2 R7
        {2'd0, 32'h0004_0000, 32'h0004_0001, 2'b01},  // R8 masked ch1 bit
        {2'd0, 32'h0001_0000, 32'h0005_0001, 2'b11},  // R7
        {2'd1, 32'hFFFF_FFFE, 32'h0005_0000, 2'b10},  // R3 clear one bit
        {2'd1, 32'hFFFF_FFFF, 32'h0005_0000, 2'b10},  // R3 ones keep
        {2'd0, 32'h0000_0202, 32'h0005_0202, 2'b11},  // R2
        {2'd1, 32'h0000_FFFF, 32'h0000_0202, 2'b01},  // R4 clear ch1
        {2'd1, 32'hFFFF_0000, 32'h0000_0000, 2'b00},  // R4 clear ch0
        {2'd2, 32'h0000_0000, 32'h0000_0000, 2'b00},  // R6
        {2'd0, 32'h0001_0001, 32'h0001_0001, 2'b00},  // R8 all masked
        {2'd2, 32'hFFFF_FFFF, 32'h0001_0001, 2'b11},  // R7 enable late
        {2'd1, 32'h0000_0000, 32'h0000_0000, 2'b00}   // R3 clear all
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read a word; result valid after return
    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic apply(input logic [1:0] kind, input logic [31:0] d);
        @(negedge clk);
        case (kind)
            2'd0: evt_i = d;
            2'd1: begin wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = d; end
            default: begin wr_en_i = 1'b1; addr_i = 2'd1; wdata_i = d; end
        endcase
        @(negedge clk);
        evt_i = '0; wr_en_i = 1'b0;
        rd_en_i = 1'b1; addr_i = 2'd0;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq", {30'd0, irq_o}, 32'd0);
        check("R1 errs", {28'd0, dec_err_o, err_o}, 32'd0);
        rd(2'd0); check("R1 cause", rdata_o, 32'd0);
        rd(2'd1); check("R1 enable", rdata_o, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][67:66], VECS[i][65:34]);
            check($sformatf("R2/R3/R4/R7/R8 vec%0d cause", i), rdata_o, VECS[i][33:2]);
            check($sformatf("R7/R8 vec%0d irq", i), {30'd0, irq_o}, {30'd0, VECS[i][1:0]});
        end

        // R5: event and clear on the same bit in one cycle
        apply(2'd0, 32'h0000_0010);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = 2'd0; wdata_i = 32'h0; evt_i = 32'h0000_0008;
        @(negedge clk);
        wr_en_i = 1'b0; evt_i = '0;
        rd(2'd0); check("R5 event beats clear", rdata_o, 32'h0000_0008);
        apply(2'd1, 32'h0);

        // R6: enable read-back, cause untouched by enable write
        apply(2'd0, 32'h0100_0000);
        apply(2'd2, 32'h1234_ABCD);
        check("R6 cause kept", rdata_o, 32'h0100_0000);
        rd(2'd1); check("R6 enable readback", rdata_o, 32'h1234_ABCD);

        // R10: unmapped write changes nothing, unmapped read is zero
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = 2'd2; wdata_i = 32'h0;
        @(negedge clk);
        wr_en_i = 1'b0;
        rd(2'd0); check("R10 cause after stray write", rdata_o, 32'h0100_0000);
        rd(2'd1); check("R10 enable after stray write", rdata_o, 32'h1234_ABCD);
        rd(2'd3); check("R10 unmapped read", rdata_o, 32'h0);

        // R11: read data holds without a read strobe
        repeat (2) @(negedge clk);
        check("R11 hold", rdata_o, 32'h0);

        // R9: decode error vs other errors
        apply(2'd1, 32'h0);
        apply(2'd0, 32'h0020_0000);   // ch1 bit 5
        check("R9 dec flag", {30'd0, dec_err_o}, 32'd2);
        check("R9 no other err", {30'd0, err_o}, 32'd0);
        apply(2'd0, 32'h0000_0040);   // ch0 bit 6
        check("R9 other err", {30'd0, err_o}, 32'd1);
        check("R9 dec flag kept", {30'd0, dec_err_o}, 32'd2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule